// File: doc/BRIEF.md
# Machine Check Exception Entry Unit

This unit decides, cycle by cycle, whether a processor core must enter its machine check handler. It also performs the register updates that belong to that entry and to the matching return. Three kinds of cause arrive on request lines: error reports, non-maskable requests, and asynchronous sources. An asynchronous source first sets a sticky syndrome bit. A pending syndrome bit becomes an exception only while the enable bit of the machine state word is 1. Error reports and non-maskable requests ignore that enable.

On entry the unit issues a one-cycle take pulse. It also produces a handler address built from a vector prefix register and a vector offset register, and a new machine state word with a fixed set of fields cleared. It saves the instruction address and the old state word in a dedicated save/restore pair. A return command redirects to the saved address and restores the saved state word. The unit holds a sticky syndrome register and an address-capture register. A small write bus lets software load the pair and the capture register, and clear syndrome bits by writing ones.

Bit numbering is big-endian throughout: bit 0 of a field description is the most significant bit of the 32-bit word, so bit k sits at vector index 31-k. All outputs are registered. When the state word changes on a take or return pulse, the unit uses its own new word in that cycle in place of the `msr_i` input, which the pipeline only updates one cycle later. This forwarding makes back-to-back causes behave as nested exceptions.

Top module: `mce_unit`

## Requirements
- R1: When `err_req_i` or `nmi_req_i` is 1 in a cycle, `take_o` is 1 in the following cycle, whatever the enable bit (bit 19) of the state word.
- R2: A 1 on `async_req_i[i]` sets syndrome bit 8+i (vector index 23-i) at the next edge. While any such bit is set and the effective state word has bit 19 equal to 1, an exception is taken (`take_o` 1 one cycle later). While bit 19 is 0 the bit stays pending and nothing is taken.
- R3: On a take, `srr0_o` receives `pc_i` and `srr1_o` receives the whole effective state word from before the exception.
- R4: On a take, `msr_o` equals the effective state word with bits 5, 6, 13, 14, 16, 17, 18, 19, 20, 23, 26, 27, 29 and 30 cleared. Bit 22 is also cleared when `CLEAR_DE` is 1 and kept when it is 0.
- R5: Syndrome bits are set by hardware only. An error report sets bit 0 (index 31), a non-maskable request sets bit 1 (index 30), and asynchronous source i sets bit 8+i. A software write with `wr_sel_i`=2 clears each bit where the data has a 1. A hardware set in the same cycle wins over the clear.
- R6: On a take, `tgt_o` is bits 0..15 of `ivpr_i`, then bits 16..27 of `ivor_i`, then four zero bits.
- R7: `rfmci_i` gives a `ret_o` pulse in the next cycle with `tgt_o`=`srr0_o` and `msr_o`=`srr1_o` as they stood before the return. If an exception is taken in the same cycle, the return is dropped and only `take_o` pulses.
- R8: A cause arriving in the cycle a take or return pulse is visible uses `msr_o` as the effective state word. So a nested take saves a copy with bit 30 equal to 0 in `srr1_o`.
- R9: `car_o` loads `err_addr_i` only when `err_req_i` and `err_addr_vld_i` are both 1. An error report without the strobe leaves it unchanged.
- R10: After reset, every output is 0.
- R11: The write bus (`wr_en_i`) with `wr_sel_i` 0, 1 or 3 loads `srr0_o`, `srr1_o` or `car_o`. A take in the same cycle wins over a write to the save/restore pair, and a strobed error address wins over a write to `car_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_req_i | input | 1 | Error-report cause |
| err_addr_vld_i | input | 1 | Fault address valid with the error report |
| err_addr_i | input | 32 | Fault address |
| nmi_req_i | input | 1 | Non-maskable cause |
| async_req_i | input | NUM_ASYNC | Asynchronous syndrome sources |
| msr_i | input | 32 | Current machine state word |
| pc_i | input | 32 | Address of the current instruction |
| ivpr_i | input | 32 | Vector prefix register |
| ivor_i | input | 32 | Vector offset register |
| rfmci_i | input | 1 | Return-from-machine-check command |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Write target: 0 srr0, 1 srr1, 2 syndrome clear, 3 capture |
| wr_data_i | input | 32 | Write data |
| take_o | output | 1 | Exception taken (one-cycle pulse) |
| ret_o | output | 1 | Return performed (one-cycle pulse) |
| tgt_o | output | 32 | Redirect address for a take or return |
| msr_o | output | 32 | New machine state word for a take or return |
| srr0_o | output | 32 | Saved instruction address |
| srr1_o | output | 32 | Saved state word |
| syn_o | output | 32 | Sticky syndrome register |
| car_o | output | 32 | Address-capture register |

## Verification
The bench builds the unit with three asynchronous sources and `CLEAR_DE` set to 0. This places the source bits at indices 23 to 21 and checks that the debug field passes through entry unchanged, which the default build would hide. A state word of all ones on entry shows exactly which fields are cleared. Held error requests and returns issued together with causes exercise the nested and priority paths. A long random phase mixes state words with the enable on and off, so pending asynchronous bits are taken and held back in turn.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam logic [1:0] WSEL_SRR0 = 2'd0;
  localparam logic [1:0] WSEL_SRR1 = 2'd1;
  localparam logic [1:0] WSEL_SYN  = 2'd2;
  localparam logic [1:0] WSEL_CAR  = 2'd3;

  // one-hot mask for a big-endian bit number (0 = MSB)
  function automatic word_t be_bit(input int pos);
    return word_t'(1) << (XLEN - 1 - pos);
  endfunction
endpackage

// File: rtl/mce_cause.sv
module mce_cause
  import mce_pkg::*;
#(
  parameter int NUM_ASYNC      = 4,
  parameter int SYN_ERR_POS    = 0,
  parameter int SYN_NMI_POS    = 1,
  parameter int SYN_ASYNC_BASE = 8,
  parameter int ME_POS         = 19
) (
  input  logic                 err_req,
  input  logic                 nmi_req,
  input  logic [NUM_ASYNC-1:0] async_req,
  input  word_t                syn_q,
  input  word_t                msr_eff,
  output word_t                syn_set,
  output logic                 take
);
  localparam int ME_IDX = XLEN - 1 - ME_POS;

  word_t amask;
  word_t aset;

  // syndrome positions of the asynchronous sources
  for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_src
    localparam int IDX = XLEN - 1 - (SYN_ASYNC_BASE + i);
    assign amask[IDX] = 1'b1;
    assign aset[IDX]  = async_req[i];
  end
  for (genvar b = 0; b < XLEN; b++) begin : g_pad
    if ((b > XLEN - 1 - SYN_ASYNC_BASE) || (b < XLEN - SYN_ASYNC_BASE - NUM_ASYNC)) begin : g_z
      assign amask[b] = 1'b0;
      assign aset[b]  = 1'b0;
    end
  end

  logic async_pend;
  assign async_pend = |(syn_q & amask);

  always_comb begin
    syn_set = aset;
    if (err_req) syn_set = syn_set | be_bit(SYN_ERR_POS);
    if (nmi_req) syn_set = syn_set | be_bit(SYN_NMI_POS);
  end

  assign take = err_req | nmi_req | (async_pend & msr_eff[ME_IDX]);
endmodule

// File: rtl/mce_regs.sv
module mce_regs
  import mce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  word_t      pc,
  input  word_t      msr_eff,
  input  word_t      syn_set,
  input  logic       cap_en,
  input  word_t      cap_addr,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  word_t      wr_data,
  output word_t      srr0_q,
  output word_t      srr1_q,
  output word_t      syn_q,
  output word_t      car_q
);
  word_t w1c;
  assign w1c = (wr_en && wr_sel == WSEL_SYN) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_q <= '0;
      srr1_q <= '0;
      syn_q  <= '0;
      car_q  <= '0;
    end else begin
      if (take) begin
        srr0_q <= pc;
        srr1_q <= msr_eff;
      end else if (wr_en && wr_sel == WSEL_SRR0) begin
        srr0_q <= wr_data;
      end else if (wr_en && wr_sel == WSEL_SRR1) begin
        srr1_q <= wr_data;
      end
      syn_q <= (syn_q & ~w1c) | syn_set;
      if (cap_en)                               car_q <= cap_addr;
      else if (wr_en && wr_sel == WSEL_CAR)     car_q <= wr_data;
    end
  end
endmodule

// File: rtl/mce_unit.sv
module mce_unit
  import mce_pkg::*;
#(
  parameter int NUM_ASYNC      = 4,
  parameter int SYN_ERR_POS    = 0,
  parameter int SYN_NMI_POS    = 1,
  parameter int SYN_ASYNC_BASE = 8,
  parameter bit CLEAR_DE       = 1'b1,
  parameter int UCLE_POS = 5,  parameter int SPE_POS = 6,  parameter int WE_POS  = 13,
  parameter int CE_POS   = 14, parameter int EE_POS  = 16, parameter int PR_POS  = 17,
  parameter int FP_POS   = 18, parameter int ME_POS  = 19, parameter int FE0_POS = 20,
  parameter int DE_POS   = 22, parameter int FE1_POS = 23, parameter int IS_POS  = 26,
  parameter int DS_POS   = 27, parameter int PMM_POS = 29, parameter int RI_POS  = 30,
  parameter int VEC_HI_BITS = 16,
  parameter int VEC_LO_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 err_req_i,
  input  logic                 err_addr_vld_i,
  input  logic [31:0]          err_addr_i,
  input  logic                 nmi_req_i,
  input  logic [NUM_ASYNC-1:0] async_req_i,
  input  logic [31:0]          msr_i,
  input  logic [31:0]          pc_i,
  input  logic [31:0]          ivpr_i,
  input  logic [31:0]          ivor_i,
  input  logic                 rfmci_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [31:0]          wr_data_i,
  output logic                 take_o,
  output logic                 ret_o,
  output logic [31:0]          tgt_o,
  output logic [31:0]          msr_o,
  output logic [31:0]          srr0_o,
  output logic [31:0]          srr1_o,
  output logic [31:0]          syn_o,
  output logic [31:0]          car_o
);
  localparam int OFF_BITS = XLEN - VEC_HI_BITS - VEC_LO_BITS;
  localparam word_t BASE_CLR =
      be_bit(UCLE_POS) | be_bit(SPE_POS) | be_bit(WE_POS)  | be_bit(CE_POS)  |
      be_bit(EE_POS)   | be_bit(PR_POS)  | be_bit(FP_POS)  | be_bit(ME_POS)  |
      be_bit(FE0_POS)  | be_bit(FE1_POS) | be_bit(IS_POS)  | be_bit(DS_POS)  |
      be_bit(PMM_POS)  | be_bit(RI_POS);
  localparam word_t CLR_MASK = CLEAR_DE ? (BASE_CLR | be_bit(DE_POS)) : BASE_CLR;

  word_t msr_eff, syn_set, vec;
  logic  take, ret_go;

  // forward the word just produced until the pipeline has picked it up
  assign msr_eff = (take_o || ret_o) ? msr_o : msr_i;
  assign ret_go  = rfmci_i & ~take;
  assign vec     = {ivpr_i[XLEN-1 -: VEC_HI_BITS],
                    ivor_i[XLEN-1-VEC_HI_BITS -: VEC_LO_BITS],
                    {OFF_BITS{1'b0}}};

  mce_cause #(
    .NUM_ASYNC(NUM_ASYNC), .SYN_ERR_POS(SYN_ERR_POS), .SYN_NMI_POS(SYN_NMI_POS),
    .SYN_ASYNC_BASE(SYN_ASYNC_BASE), .ME_POS(ME_POS)
  ) cause_i (
    .err_req(err_req_i), .nmi_req(nmi_req_i), .async_req(async_req_i),
    .syn_q(syn_o), .msr_eff(msr_eff), .syn_set(syn_set), .take(take)
  );

  mce_regs regs_i (
    .clk(clk), .rst(rst), .take(take), .pc(pc_i), .msr_eff(msr_eff),
    .syn_set(syn_set), .cap_en(err_req_i & err_addr_vld_i), .cap_addr(err_addr_i),
    .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
    .srr0_q(srr0_o), .srr1_q(srr1_o), .syn_q(syn_o), .car_q(car_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      ret_o  <= 1'b0;
      tgt_o  <= '0;
      msr_o  <= '0;
    end else begin
      take_o <= take;
      ret_o  <= ret_go;
      if (take) begin
        tgt_o <= vec;
        msr_o <= msr_eff & ~CLR_MASK;
      end else if (ret_go) begin
        tgt_o <= srr0_o;
        msr_o <= srr1_o;
      end
    end
  end
endmodule

// File: rtl/mce_unit_chk.sv
module mce_unit_chk #(
  parameter int          ME_POS   = 19,
  parameter logic [31:0] CLR_MASK = '0
) (
  input logic        clk,
  input logic        rst,
  input logic        err_req_i,
  input logic        nmi_req_i,
  input logic [31:0] msr_i,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic        take_o,
  input logic        ret_o,
  input logic [31:0] tgt_o,
  input logic [31:0] msr_o,
  input logic [31:0] srr1_o,
  input logic [31:0] syn_o
);
  localparam int ME_IDX = 31 - ME_POS;

  a_r1_err_nmi_taken: assert property (@(posedge clk) disable iff (rst)
    (err_req_i || nmi_req_i) |=> take_o);

  a_r2_async_gated: assert property (@(posedge clk) disable iff (rst)
    (!take_o && !ret_o && !msr_i[ME_IDX] && !err_req_i && !nmi_req_i) |=> !take_o);

  a_r4_entry_word: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (msr_o == (srr1_o & ~CLR_MASK)));

  a_r5_syn_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && wr_sel_i == 2'd2) |=> ((syn_o & $past(syn_o)) == $past(syn_o)));

  a_r6_vec_aligned: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (tgt_o[3:0] == 4'd0));

  a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_o, ret_o}));

  a_r7_ret_word: assert property (@(posedge clk) disable iff (rst)
    ret_o |-> (msr_o == $past(srr1_o)));
endmodule

bind mce_unit mce_unit_chk #(.ME_POS(ME_POS), .CLR_MASK(CLR_MASK)) chk_i (
  .clk(clk), .rst(rst), .err_req_i(err_req_i), .nmi_req_i(nmi_req_i),
  .msr_i(msr_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .take_o(take_o),
  .ret_o(ret_o), .tgt_o(tgt_o), .msr_o(msr_o), .srr1_o(srr1_o), .syn_o(syn_o)
);

// File: tb/mce_unit_tb_top.sv
`timescale 1ns/100ps
module mce_unit_tb_top;
  localparam int NA = 3;
  localparam logic [31:0] ME = 32'h1 << (31 - 19);
  localparam logic [31:0] RI = 32'h1 << (31 - 30);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic err = 0, vld = 0, nmi = 0, rfmci = 0, wr_en = 0;
  logic [31:0] eaddr = 0, sw_msr = 0, pc = 0, ivpr = 0, ivor = 0, wdata = 0;
  logic [NA-1:0] asy = 0;
  logic [1:0] wsel = 0;
  logic take, ret;
  logic [31:0] tgt, msro, srr0, srr1, syn, car;

  int total = 0, bad = 0;

  mce_unit #(.NUM_ASYNC(NA), .CLEAR_DE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .err_req_i(err), .err_addr_vld_i(vld), .err_addr_i(eaddr),
    .nmi_req_i(nmi), .async_req_i(asy), .msr_i(sw_msr), .pc_i(pc), .ivpr_i(ivpr),
    .ivor_i(ivor), .rfmci_i(rfmci), .wr_en_i(wr_en), .wr_sel_i(wsel), .wr_data_i(wdata),
    .take_o(take), .ret_o(ret), .tgt_o(tgt), .msr_o(msro), .srr0_o(srr0),
    .srr1_o(srr1), .syn_o(syn), .car_o(car)
  );

  // fields cleared on entry (debug field kept in this build)
  function automatic logic [31:0] clr_mask();
    int pos[14] = '{5, 6, 13, 14, 16, 17, 18, 19, 20, 23, 26, 27, 29, 30};
    logic [31:0] m = 0;
    foreach (pos[k]) m[31 - pos[k]] = 1'b1;
    return m;
  endfunction

  // behavioural reference
  logic m_take = 0, m_ret = 0;
  logic [31:0] m_tgt = 0, m_msr = 0, m_srr0 = 0, m_srr1 = 0, m_syn = 0, m_car = 0;
  always @(posedge clk) begin
    logic [31:0] eff, setv, n_srr0, n_srr1, n_syn, n_car, n_tgt, n_msr;
    logic tk, rt;
    if (rst) begin
      m_take = 0; m_ret = 0; m_tgt = 0; m_msr = 0;
      m_srr0 = 0; m_srr1 = 0; m_syn = 0; m_car = 0;
    end else begin
      eff = (m_take || m_ret) ? m_msr : sw_msr;
      setv = 0;
      if (err) setv[31] = 1'b1;
      if (nmi) setv[30] = 1'b1;
      for (int i = 0; i < NA; i++) if (asy[i]) setv[23 - i] = 1'b1;
      tk = err || nmi || (((m_syn >> (23 - NA + 1)) & ((1 << NA) - 1)) != 0 && eff[12]);
      rt = rfmci && !tk;
      n_tgt = m_tgt; n_msr = m_msr; n_srr0 = m_srr0; n_srr1 = m_srr1; n_car = m_car;
      if (tk) begin
        n_tgt = {ivpr[31:16], ivor[15:4], 4'h0};
        n_msr = eff & ~clr_mask();
        n_srr0 = pc; n_srr1 = eff;
      end else begin
        if (rt) begin n_tgt = m_srr0; n_msr = m_srr1; end
        if (wr_en && wsel == 0) n_srr0 = wdata;
        if (wr_en && wsel == 1) n_srr1 = wdata;
      end
      n_syn = m_syn;
      if (wr_en && wsel == 2) n_syn = n_syn & ~wdata;
      n_syn = n_syn | setv;
      if (err && vld) n_car = eaddr;
      else if (wr_en && wsel == 3) n_car = wdata;
      m_take = tk; m_ret = rt; m_tgt = n_tgt; m_msr = n_msr;
      m_srr0 = n_srr0; m_srr1 = n_srr1; m_syn = n_syn; m_car = n_car;
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  // one clock: compare with the reference, mirror the state word, drop one-shot inputs
  task automatic tick();
    @(posedge clk);
    #1;
    chk("R1 take", {31'b0, take}, {31'b0, m_take});
    chk("R7 ret", {31'b0, ret}, {31'b0, m_ret});
    chk("R6 tgt", tgt, m_tgt);
    chk("R4 msr", msro, m_msr);
    chk("R3 srr0", srr0, m_srr0);
    chk("R3 srr1", srr1, m_srr1);
    chk("R5 syn", syn, m_syn);
    chk("R9 car", car, m_car);
    if (take || ret) sw_msr = msro;
    err = 0; vld = 0; nmi = 0; asy = 0; rfmci = 0; wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 take after reset", {31'b0, take}, 0);
    chk("R10 srr1 after reset", srr1, 0);
    chk("R10 syn after reset", syn, 0);
    chk("R10 msr after reset", msro, 0);
    rst = 0;
    ivpr = 32'h1234_5678; ivor = 32'h0000_0ABC; pc = 32'h0000_4000;

    // R1: error report with enable clear
    sw_msr = 32'hFFFF_FFFF & ~ME;
    err = 1; vld = 1; eaddr = 32'hDEAD_0010;
    tick();
    chk("R1 err taken with ME=0", {31'b0, take}, 1);
    chk("R9 car captured", car, 32'hDEAD_0010);
    chk("R3 srr1 saved word", srr1, 32'hFFFF_FFFF & ~ME);
    chk("R6 vector", tgt, 32'h1234_0AB0);
    chk("R4 entry word keeps DE", msro, 32'hFFFF_FFFF & ~clr_mask() & ~ME);
    chk("R5 err syndrome bit", {31'b0, syn[31]}, 1);
    tick();
    // R1: non-maskable with enable clear
    nmi = 1; pc = 32'h0000_4004;
    tick();
    chk("R1 nmi taken with ME=0", {31'b0, take}, 1);
    chk("R3 srr0 pc", srr0, 32'h0000_4004);
    tick();
    // R2: asynchronous source held while disabled
    asy = 3'b010;
    tick();
    chk("R2 async bit set", {31'b0, syn[22]}, 1);
    repeat (3) begin tick(); chk("R2 held while ME=0", {31'b0, take}, 0); end
    sw_msr = sw_msr | ME | RI;
    tick();
    chk("R2 taken once ME=1", {31'b0, take}, 1);
    tick();
    chk("R2 no retake after entry", {31'b0, take}, 0);
    // R5: clear by write-one, hardware set wins
    wr_en = 1; wsel = 2; wdata = 32'hFFFF_FFFF;
    tick();
    chk("R5 w1c clears", syn, 0);
    err = 1; wr_en = 1; wsel = 2; wdata = 32'h8000_0000;
    tick();
    chk("R5 set beats clear", {31'b0, syn[31]}, 1);
    tick();
    // R7: return
    wr_en = 1; wsel = 0; wdata = 32'h0000_8888;
    tick();
    chk("R11 srr0 write", srr0, 32'h0000_8888);
    keep = srr1;
    rfmci = 1;
    tick();
    chk("R7 return pulse", {31'b0, ret}, 1);
    chk("R7 return target", tgt, 32'h0000_8888);
    chk("R7 return word", msro, keep);
    tick();
    rfmci = 1; err = 1;
    tick();
    chk("R7 take beats return", {ret, take}, 32'h1);
    tick();
    // R8: nested entry
    sw_msr = ME | RI;
    err = 1;
    tick();
    chk("R8 first save RI=1", {31'b0, srr1[1]}, 1);
    err = 1;
    tick();
    chk("R8 nested save RI=0", {31'b0, srr1[1]}, 0);
    tick();
    // R11: take beats write to srr1, error address beats car write
    sw_msr = 32'h0000_0F0F;
    err = 1; vld = 1; eaddr = 32'h0000_00A0; wr_en = 1; wsel = 1; wdata = 32'h5555_5555;
    tick();
    chk("R11 take beats srr1 write", srr1, 32'h0000_0F0F);
    tick();
    wr_en = 1; wsel = 3; wdata = 32'h0000_0C00;
    tick();
    chk("R11 car write", car, 32'h0000_0C00);
    err = 1; vld = 0; eaddr = 32'hFFFF_0000;
    tick();
    chk("R9 no strobe keeps car", car, 32'h0000_0C00);
    tick();
    // random mix
    for (int n = 0; n < 600; n++) begin
      err = ($urandom % 10) == 0;
      vld = $urandom % 2;
      eaddr = $urandom;
      nmi = ($urandom % 16) == 0;
      asy = (($urandom % 6) == 0) ? NA'($urandom) : '0;
      rfmci = ($urandom % 8) == 0;
      wr_en = ($urandom % 5) == 0;
      wsel = 2'($urandom);
      wdata = $urandom;
      pc = $urandom;
      if (($urandom % 7) == 0) sw_msr = $urandom;
      tick();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule